// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Register Block

This block sits beside one processor core. It keeps a 32-bit word of pending interprocessor interrupt bits, a 32-bit enable mask, and eight 32-bit mailbox words that other agents can use to pass small messages. Software reaches all of it through a simple 32-bit register bus with address, write strobe, read strobe, write data and read data. The block drives one interrupt level toward its core.

Pending bits change only through two write-only doors. Writing ones to the set register adds bits, and writing ones to the clear register removes them. The interrupt level is re-evaluated only on those two writes. A set write raises the level when an enabled bit is pending. A clear write drops the level only when nothing remains pending and the enable mask is nonzero. Changing the enable mask by itself never moves the level. Accesses to the read-only status word with a write, and any access to an undefined offset, raise a one-cycle error flag.

Top module: `ipi_core_regs`

## Requirements
- R1: Decode uses only address bits [7:0]. Offsets: status 0x00, enable 0x04, set 0x08, clear 0x0C. Mailbox word k sits at 0x20 + 4*k for k = 0..7, so the last word is at 0x3C.
- R2: After reset, status, enable and all mailbox words are zero, and irq_o, err_o and rd_data are low.
- R3: A read strobe returns the addressed value on rd_data in the cycle after the strobe. In cycles with no read, rd_data is zero.
- R4: A write to enable replaces the whole 32-bit mask, and the mask reads back unchanged.
- R5: A write to set ORs the write data into status. irq_o goes high on the next cycle if the new status ANDed with enable is nonzero. Otherwise irq_o keeps its value.
- R6: A write to clear computes status AND NOT data. irq_o goes low on the next cycle only if the new status is zero and enable is nonzero. Otherwise irq_o keeps its value.
- R7: Writes to enable, mailbox words or undefined offsets never change irq_o.
- R8: Set and clear always read back as zero.
- R9: A write to status leaves status unchanged and pulses err_o for one cycle.
- R10: A read or write at an undefined offset reads zero, changes no state, and pulses err_o high for one cycle. Defined accesses leave err_o low.
- R11: All eight mailbox words can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Register address; only bits [7:0] are decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle access error pulse |
| irq_o | output | 1 | Interrupt level toward the core |

## Verification
The hardest state to reach is the one where irq_o stays high while nothing is pending. To get there, the stimulus raises the interrupt with an enabled bit, sets the enable mask to zero, and then clears every pending bit. Because the clear rule requires a nonzero mask, the level has to survive. A later clear with a nonzero mask must then drop it. Random sequences reach the same states by mixing mask rewrites with set and clear writes whose data is mostly sparse. Upper address bits are also randomized to check that only bits [7:0] are decoded.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;

    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBOX,
        SEL_NONE
    } reg_sel_e;

    localparam logic [7:0] OFS_STAT    = 8'h00;
    localparam logic [7:0] OFS_MASK    = 8'h04;
    localparam logic [7:0] OFS_SET     = 8'h08;
    localparam logic [7:0] OFS_CLR     = 8'h0C;
    localparam logic [7:0] OFS_MBOX_LO = 8'h20;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_regs_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic [7:0]       ofs,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] idx
);
    localparam int MBOX_END = 32'(OFS_MBOX_LO) + 4 * MBOX_WORDS;

    logic [7:0] rel;

    always_comb begin
        rel = ofs - OFS_MBOX_LO;
        idx = rel[IDX_W+1:2];
        if (ofs == OFS_STAT)
            sel = SEL_STAT;
        else if (ofs == OFS_MASK)
            sel = SEL_MASK;
        else if (ofs == OFS_SET)
            sel = SEL_SET;
        else if (ofs == OFS_CLR)
            sel = SEL_CLR;
        else if (ofs >= OFS_MBOX_LO && 32'(ofs) < MBOX_END)
            sel = SEL_MBOX;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word_d [WORDS];
    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        always_comb begin
            word_d[k] = word_q[k];
            if (we && 32'(idx) == k)
                word_d[k] = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[k] <= '0;
            else
                word_q[k] <= word_d[k];
        end

        // R11
        word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && 32'(idx) == k) |=> $stable(word_q[k]));
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < WORDS; k++)
            if (32'(idx) == k)
                rdata = word_q[k];
    end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mask;
        logic              irq;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } core_state_t;

    core_state_t       st_d, st_q;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  mb_idx;
    logic              mb_we;
    logic [DATA_W-1:0] mb_rdata;

    ipi_decode #(.MBOX_WORDS(MBOX_WORDS)) u_dec (
        .ofs (addr[7:0]),
        .sel (sel),
        .idx (mb_idx)
    );

    ipi_mailbox #(.WORDS(MBOX_WORDS), .DATA_W(DATA_W)) u_mbox (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mb_we),
        .idx   (mb_idx),
        .wdata (wr_data),
        .rdata (mb_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.rdata = '0;
        mb_we      = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_STAT: st_d.err  = 1'b1;
                SEL_MASK: st_d.mask = wr_data;
                SEL_SET: begin
                    st_d.stat = st_q.stat | wr_data;
                    if (st_d.stat != '0 && (st_d.stat & st_q.mask) != '0)
                        st_d.irq = 1'b1;
                end
                SEL_CLR: begin
                    st_d.stat = st_q.stat & ~wr_data;
                    if (st_d.stat == '0 && st_q.mask != '0)
                        st_d.irq = 1'b0;
                end
                SEL_MBOX: mb_we = 1'b1;
                default:  st_d.err = 1'b1;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_STAT: st_d.rdata = st_q.stat;
                SEL_MASK: st_d.rdata = st_q.mask;
                SEL_SET,
                SEL_CLR:  st_d.rdata = '0;
                SEL_MBOX: st_d.rdata = mb_rdata;
                default:  st_d.err   = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign err_o   = st_q.err;
    assign irq_o   = st_q.irq;

    // R5 R7
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(wr_en && addr[7:0] == OFS_SET));

    // R6 R7
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(wr_en && addr[7:0] == OFS_CLR));

    // R9
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT) |=> $stable(st_q.stat) && err_o);

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MASK) |=> st_q.mask == $past(wr_data));

    // R8
    setclr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_SET || sel == SEL_CLR)) |=> rd_data == '0);

    // R3
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past((wr_en || rd_en) && sel == SEL_NONE) ||
                  $past(wr_en && sel == SEL_STAT));
endmodule

// File: tb/ipi_core_regs_test.sv
module ipi_core_regs_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        err_o;
    logic        irq_o;

    int vectors = 0;
    int fails   = 0;

    logic [31:0] m_stat, m_mask;
    logic [31:0] m_mbox [8];
    logic        m_irq;

    always #5 clk = ~clk;

    ipi_core_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .err_o(err_o), .irq_o(irq_o)
    );

    function automatic bit is_mbox(input logic [7:0] o);
        return o >= 8'h20 && o < 8'h40;
    endfunction

    function automatic bit is_undef(input logic [7:0] o);
        return !(o == 8'h00 || o == 8'h04 || o == 8'h08 || o == 8'h0C || is_mbox(o));
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] o);
        if (o == 8'h00) return m_stat;
        if (o == 8'h04) return m_mask;
        if (is_mbox(o)) return m_mbox[(o - 8'h20) >> 2];
        return 32'h0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
        logic [7:0] o;
        logic       e_err;
        o = a[7:0];
        e_err = (o == 8'h00) || is_undef(o);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        if (o == 8'h04) m_mask = d;
        else if (o == 8'h08) begin
            m_stat = m_stat | d;
            if ((m_stat & m_mask) != 0) m_irq = 1'b1;
        end else if (o == 8'h0C) begin
            m_stat = m_stat & ~d;
            if (m_stat == 0 && m_mask != 0) m_irq = 1'b0;
        end else if (is_mbox(o)) m_mbox[(o - 8'h20) >> 2] = d;
        @(negedge clk);
        wr_en = 1'b0;
        check({31'b0, irq_o}, {31'b0, m_irq}, {req, " irq"});
        check({31'b0, err_o}, {31'b0, e_err}, {req, " err"});
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        logic [31:0] e;
        e = exp_read(a[7:0]);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data, e, {req, " rdata"});
        check({31'b0, err_o}, {31'b0, is_undef(a[7:0])}, {req, " err"});
        @(negedge clk);
        check(rd_data, 32'h0, "R3 idle rdata");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        m_stat = '0; m_mask = '0; m_irq = 1'b0;
        for (int k = 0; k < 8; k++) m_mbox[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({31'b0, irq_o}, 32'h0, "R2 irq");
        check({31'b0, err_o}, 32'h0, "R2 err");
        check(rd_data, 32'h0, "R2 rdata");
        rd(16'h0000, "R2 stat");
        rd(16'h0004, "R2 mask");
        rd(16'h003C, "R2 mbox");

        wr(16'h0004, 32'hA5A5_0F0F, "R4 mask");
        rd(16'h0004, "R4 mask");
        wr(16'h0004, 32'h0000_0000, "R4 mask zero");
        wr(16'h0008, 32'h0000_0010, "R5 set masked");
        check({31'b0, irq_o}, 32'h0, "R5 no raise");
        wr(16'h0004, 32'h0000_0010, "R7 mask no raise");
        check({31'b0, irq_o}, 32'h0, "R7 level kept");
        wr(16'h0008, 32'h0000_0001, "R5 set");
        check({31'b0, irq_o}, 32'h1, "R5 raised");
        rd(16'h0008, "R8 set reads zero");
        rd(16'h000C, "R8 clr reads zero");
        wr(16'h000C, 32'h0000_0001, "R6 partial clear");
        check({31'b0, irq_o}, 32'h1, "R6 still pending");
        wr(16'h0004, 32'h0000_0000, "R7 mask off");
        wr(16'h000C, 32'hFFFF_FFFF, "R6 clear with zero mask");
        check({31'b0, irq_o}, 32'h1, "R6 held high");
        rd(16'h0000, "R6 stat empty");
        wr(16'h0004, 32'h0000_0002, "R7 mask on");
        wr(16'h000C, 32'h0000_0000, "R6 clear nonzero mask");
        check({31'b0, irq_o}, 32'h0, "R6 dropped");
        wr(16'h0008, 32'h0000_0006, "R5 set");
        wr(16'h0000, 32'h0000_0000, "R9 stat write");
        rd(16'h0000, "R9 stat unchanged");
        rd(16'h0010, "R10 undef read");
        rd(16'h0040, "R10 past mailbox");
        wr(16'h00FC, 32'hDEAD_BEEF, "R10 undef write");
        rd(16'hAB04, "R1 alias mask");
        wr(16'h7F08, 32'h8000_0000, "R1 alias set");
        rd(16'h0000, "R1 stat");
        for (int k = 0; k < 8; k++)
            wr(16'(32'h20 + 4 * k), 32'h1111_1111 * (k + 1), "R11 mbox write");
        for (int k = 0; k < 8; k++)
            rd(16'(32'h20 + 4 * k), "R11 mbox read");
        wr(16'h1F3C, 32'h0BAD_CAFE, "R11 last word");
        rd(16'h003C, "R11 last word");

        for (int n = 0; n < 400; n++) begin
            logic [7:0]  o;
            logic [15:0] a;
            logic [31:0] d;
            int          pick;
            pick = int'($urandom % 16);
            if (pick < 4)       o = 8'(pick * 4);
            else if (pick < 12) o = 8'(32'h20 + 4 * (pick - 4));
            else if (pick == 12) o = 8'h10;
            else if (pick == 13) o = 8'h44;
            else                o = 8'(4 * ($urandom % 4));
            a = {8'($urandom), o};
            d = ($urandom % 2 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
            if ($urandom % 2 == 0) wr(a, d, "R5 R6 R7 random write");
            else rd(a, "R3 random read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule